// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This controller-side block takes an SDRAM from power-on to a usable state. Reset acts as the start signal. While reset is held, the block captures its configuration inputs and the length of the stabilization pause. Once reset is released, it raises clock enable and issues no-operation commands for the programmed number of cycles.

It then closes every bank with a single precharge-all and issues a fixed number of auto-refresh commands. It writes the mode register with the captured CAS latency, burst length, burst type and write-burst setting. One input selects whether the refreshes come before or after the mode-register write. A recovery gap of NOP cycles follows each precharge and each refresh. When the last step completes, `ready` rises and stays high until the next reset. The memory controller that owns the bus afterwards can then take over.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst` is sampled high, `cke` is low, `cs_n` is high (deselect) and `ready` is low. All configuration inputs and `wait_cycles` are captured on each such edge.
- R2: From the first rising edge after `rst` is released, `cke` stays high until reset is asserted again.
- R3: Every command before the precharge is NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1). The precharge-all first appears after rising edge number `wait_cycles`+1 following reset release.
- R4: Precharge-all is encoded `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with `addr[10]`=1 and `bank`=0. It is followed by exactly TRP_CYC NOP cycles.
- R5: Exactly NUM_REFRESH auto-refresh commands are issued per sequence, encoded `cs_n`=`ras_n`=`cas_n`=0 and `we_n`=1. Each is followed by exactly TRFC_CYC NOP cycles.
- R6: The mode-register write is encoded with all four command pins low and `bank`=0. It places `addr[2:0]` = burst length code (000=1, 001=2, 010=4, 011=8, 111=full page, sequential only), `addr[3]` = burst type (1 = interleaved), `addr[6:4]` = CAS latency code (010=2, 011=3) and `addr[9]` = write-burst mode (1 = single-location writes). `addr[11:10]` and `addr[8:7]` are 0.
- R7: With `refresh_first`=1, all refreshes precede the mode-register write. `ready` rises on the edge right after that write.
- R8: With `refresh_first`=0, the mode-register write comes directly after the precharge gap. The first refresh follows on the next cycle. `ready` rises once the last refresh's TRFC_CYC gap has elapsed.
- R9: Once `ready` is high, it stays high with NOP commands and `cke` high. Asserting `rst` at any point, including mid-sequence, drops `ready` and restarts the whole sequence.
- R10: Changes to the configuration inputs after reset release have no effect on the command order or on the mode-register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset and sequence start |
| wait_cycles | input | WAIT_W | Stabilization pause length in cycles |
| cas_lat_code | input | 3 | CAS latency code for the mode register |
| burst_len_code | input | 3 | Burst length code for the mode register |
| burst_interleave | input | 1 | Burst type: 1 interleaved, 0 sequential |
| write_single | input | 1 | Write-burst mode: 1 single-location writes |
| refresh_first | input | 1 | 1: refreshes before mode write; 0: mode write first |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bank | output | 2 | Bank select |
| addr | output | 12 | Address bus |
| ready | output | 1 | Initialization complete |

## Verification
A vector table varies the pause length and the order selector together with the mode fields. The zero-length and one-cycle pauses expose off-by-one errors in the pause counter. A long pause shows that the counter reloads on every restart. Both values of the order selector separate a correct step ordering from a swapped or merged one. Mode fields with distinct bit patterns, including full page, interleaved bursts and single-location writes, expose any misplaced or swapped field in the mode word. Directed runs then change the configuration after release, reset mid-sequence and hold the ready state. These runs show that the settings are captured only at reset and that a restart repeats the full sequence.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_PRE,
        ST_REF,
        ST_MRS,
        ST_GAP,
        ST_READY
    } init_state_t;

    typedef struct packed {
        logic [2:0] cas_code;
        logic [2:0] bl_code;
        logic       interleave;
        logic       single_write;
        logic       refresh_first;
    } init_cfg_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_DESEL = 4'b1111;
    localparam cmd_pins_t CMD_NOP   = 4'b0111;
    localparam cmd_pins_t CMD_PRE   = 4'b0010;
    localparam cmd_pins_t CMD_REF   = 4'b0001;
    localparam cmd_pins_t CMD_MRS   = 4'b0000;

    localparam int ADDR_W = 12;
    localparam int BANK_W = 2;
    localparam int PRE_ALL_BIT = 10;

    // Mode word layout: [2:0] burst length, [3] burst type,
    // [6:4] CAS latency, [9] write-burst mode, remaining bits zero.
    function automatic logic [ADDR_W-1:0] build_mode_word(input init_cfg_t c);
        logic [ADDR_W-1:0] w;
        w      = '0;
        w[2:0] = c.bl_code;
        w[3]   = c.interleave;
        w[6:4] = c.cas_code;
        w[9]   = c.single_write;
        return w;
    endfunction

    // Picks the step that follows a finished gap or a mode write.
    function automatic init_state_t pick_next(input logic more_refs,
                                              input logic mode_done,
                                              input logic ref_first);
        if (more_refs && (ref_first || mode_done))
            return ST_REF;
        else if (!mode_done)
            return ST_MRS;
        else
            return ST_READY;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_mode_enc.sv
module sdram_init_mode_enc
    import sdram_init_pkg::*;
(
    input  init_cfg_t         cfg,
    output logic [ADDR_W-1:0] mode_word
);
    always_comb mode_word = build_mode_word(cfg);
endmodule

// File: rtl/sdram_init_cmd_drive.sv
module sdram_init_cmd_drive
    import sdram_init_pkg::*;
(
    input  init_state_t       state,
    input  logic              clk_en,
    input  logic [ADDR_W-1:0] mode_word,
    output cmd_pins_t         pins,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        pins = CMD_NOP;
        bank = '0;
        addr = '0;
        if (!clk_en) begin
            pins = CMD_DESEL;
        end else begin
            unique case (state)
                ST_PRE: begin
                    pins              = CMD_PRE;
                    addr[PRE_ALL_BIT] = 1'b1;
                end
                ST_REF: pins = CMD_REF;
                ST_MRS: begin
                    pins = CMD_MRS;
                    addr = mode_word;
                end
                default: pins = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int WAIT_W      = 16,
    parameter int TRP_CYC     = 2,
    parameter int TRFC_CYC    = 6,
    parameter int NUM_REFRESH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic [2:0]        cas_lat_code,
    input  logic [2:0]        burst_len_code,
    input  logic              burst_interleave,
    input  logic              write_single,
    input  logic              refresh_first,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        bank,
    output logic [11:0]       addr,
    output logic              ready
);
    localparam int REF_W = $clog2(NUM_REFRESH + 1);
    localparam logic [WAIT_W-1:0] TRP_LOAD  = WAIT_W'(TRP_CYC - 1);
    localparam logic [WAIT_W-1:0] TRFC_LOAD = WAIT_W'(TRFC_CYC - 1);
    localparam logic [REF_W-1:0]  REF_INIT  = REF_W'(NUM_REFRESH);

    init_state_t      state_q;
    init_cfg_t        cfg_q;
    logic [REF_W-1:0] refs_left_q;
    logic             mode_done_q;
    logic             cke_q;
    logic             t_load;
    logic [WAIT_W-1:0] t_val;
    logic             t_zero;
    logic [ADDR_W-1:0] mode_word;
    cmd_pins_t        pins;

    // Timer reload: pause length during reset, recovery gaps after commands
    always_comb begin
        t_load = 1'b1;
        t_val  = '0;
        if (rst)
            t_val = wait_cycles;
        else if (state_q == ST_PRE)
            t_val = TRP_LOAD;
        else if (state_q == ST_REF)
            t_val = TRFC_LOAD;
        else
            t_load = 1'b0;
    end

    sdram_init_timer #(.CNT_W(WAIT_W)) timer_i (
        .clk      (clk),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_WAIT;
            refs_left_q <= REF_INIT;
            mode_done_q <= 1'b0;
            cke_q       <= 1'b0;
            cfg_q       <= '{cas_code:      cas_lat_code,
                             bl_code:       burst_len_code,
                             interleave:    burst_interleave,
                             single_write:  write_single,
                             refresh_first: refresh_first};
        end else begin
            cke_q <= 1'b1;
            unique case (state_q)
                ST_WAIT:  if (t_zero) state_q <= ST_PRE;
                ST_PRE:   state_q <= ST_GAP;
                ST_REF: begin
                    state_q     <= ST_GAP;
                    refs_left_q <= refs_left_q - 1'b1;
                end
                ST_GAP: if (t_zero)
                    state_q <= pick_next(refs_left_q != '0, mode_done_q,
                                         cfg_q.refresh_first);
                ST_MRS: begin
                    mode_done_q <= 1'b1;
                    state_q     <= pick_next(refs_left_q != '0, 1'b1,
                                             cfg_q.refresh_first);
                end
                default: state_q <= ST_READY;
            endcase
        end
    end

    sdram_init_mode_enc mode_i (
        .cfg       (cfg_q),
        .mode_word (mode_word)
    );

    sdram_init_cmd_drive drive_i (
        .state     (state_q),
        .clk_en    (cke_q),
        .mode_word (mode_word),
        .pins      (pins),
        .bank      (bank),
        .addr      (addr)
    );

    assign cke   = cke_q;
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign ready = (state_q == ST_READY);
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int NUM_REFRESH = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        cke,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  bank,
    input logic [11:0] addr,
    input logic        ready
);
    logic [3:0] pins;
    logic       is_nop, is_pre, is_ref, is_mrs;
    logic [7:0] ref_seen;
    logic       mrs_seen;

    assign pins   = {cs_n, ras_n, cas_n, we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);
    assign is_mrs = (pins == 4'b0000);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_seen <= '0;
            mrs_seen <= 1'b0;
        end else begin
            if (is_ref) ref_seen <= ref_seen + 1'b1;
            if (is_mrs) mrs_seen <= 1'b1;
        end
    end

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> cke);
    // R4
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> (addr[10] && bank == 2'b00));
    // R4
    pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
        is_pre |=> is_nop);
    // R5
    ref_gap_chk: assert property (@(posedge clk) disable iff (rst)
        is_ref |=> is_nop);
    // R6
    mrs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        is_mrs |-> (bank == 2'b00 && addr[11:10] == 2'b00 && addr[8:7] == 2'b00));
    // R7
    ready_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (mrs_seen && ref_seen == 8'(NUM_REFRESH)));
    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (is_nop && cke));
endmodule

bind sdram_init_seq sdram_init_chk #(.NUM_REFRESH(NUM_REFRESH)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .bank  (bank),
    .addr  (addr),
    .ready (ready)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;
    localparam int WAIT_W = 16;
    localparam int TRP    = 2;
    localparam int TRFC   = 6;
    localparam int NREF   = 2;

    localparam int K_NOP = 0, K_PRE = 1, K_REF = 2, K_MRS = 3, K_RDY = 4, K_BAD = 7;

    typedef struct packed {
        logic [15:0] w;
        logic [2:0]  cas;
        logic [2:0]  bl;
        logic        it;
        logic        ws;
        logic        rf;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{w: 16'd5,  cas: 3'b010, bl: 3'b011, it: 1'b0, ws: 1'b0, rf: 1'b1},
        '{w: 16'd0,  cas: 3'b011, bl: 3'b111, it: 1'b0, ws: 1'b1, rf: 1'b0},
        '{w: 16'd12, cas: 3'b010, bl: 3'b000, it: 1'b1, ws: 1'b0, rf: 1'b0},
        '{w: 16'd1,  cas: 3'b011, bl: 3'b010, it: 1'b1, ws: 1'b1, rf: 1'b1},
        '{w: 16'd20, cas: 3'b011, bl: 3'b001, it: 1'b0, ws: 1'b0, rf: 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [WAIT_W-1:0] wait_cycles = '0;
    logic [2:0] cas_lat_code = 3'b010;
    logic [2:0] burst_len_code = 3'b000;
    logic burst_interleave = 1'b0;
    logic write_single = 1'b0;
    logic refresh_first = 1'b1;
    logic cke, cs_n, ras_n, cas_n, we_n, ready;
    logic [1:0] bank;
    logic [11:0] addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sdram_init_seq #(.WAIT_W(WAIT_W), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
                     .NUM_REFRESH(NREF)) dut_i (
        .clk(clk), .rst(rst), .wait_cycles(wait_cycles),
        .cas_lat_code(cas_lat_code), .burst_len_code(burst_len_code),
        .burst_interleave(burst_interleave), .write_single(write_single),
        .refresh_first(refresh_first), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .bank(bank), .addr(addr), .ready(ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sampled_kind();
        logic [3:0] p = {cs_n, ras_n, cas_n, we_n};
        if (p == 4'b0111) return ready ? K_RDY : K_NOP;
        if (p == 4'b0010) return K_PRE;
        if (p == 4'b0001) return K_REF;
        if (p == 4'b0000) return K_MRS;
        return K_BAD;
    endfunction

    // Expected command after rising edge e following reset release
    function automatic int exp_kind(input int e, input int w, input bit rf);
        int p = w + 1;
        int base = p + TRP + 1;
        if (e < p) return K_NOP;
        if (e == p) return K_PRE;
        if (e < base) return K_NOP;
        if (rf) begin
            for (int i = 0; i < NREF; i++)
                if (e == base + i * (TRFC + 1)) return K_REF;
            if (e == base + NREF * (TRFC + 1)) return K_MRS;
            if (e > base + NREF * (TRFC + 1)) return K_RDY;
        end else begin
            if (e == base) return K_MRS;
            for (int i = 0; i < NREF; i++)
                if (e == base + 1 + i * (TRFC + 1)) return K_REF;
            if (e >= base + 1 + NREF * (TRFC + 1)) return K_RDY;
        end
        return K_NOP;
    endfunction

    function automatic logic [11:0] exp_mode(input vec_t v);
        return {2'b00, v.ws, 2'b00, v.cas, v.it, v.bl};
    endfunction

    task automatic apply_reset(input vec_t v);
        @(negedge clk);
        rst = 1'b1;
        wait_cycles = v.w;
        cas_lat_code = v.cas;
        burst_len_code = v.bl;
        burst_interleave = v.it;
        write_single = v.ws;
        refresh_first = v.rf;
        @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(cke == 1'b0 && cs_n == 1'b1 && ready == 1'b0, "R1", {cke, cs_n, ready}, 3'b010);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs a full sequence; scramble=1 changes inputs after release (R10)
    task automatic run_seq(input vec_t v, input bit scramble);
        int last = int'(v.w) + 1 + TRP + 1 + NREF * (TRFC + 1) + 4;
        int got;
        int exp;
        apply_reset(v);
        for (int e = 1; e <= last; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (scramble && e == 1) begin
                wait_cycles = v.w + 16'd7;
                cas_lat_code = ~v.cas;
                burst_len_code = ~v.bl;
                burst_interleave = ~v.it;
                write_single = ~v.ws;
                refresh_first = ~v.rf;
            end
            got = sampled_kind();
            exp = exp_kind(e, int'(v.w), v.rf);
            // R3 R4 R5 R7 R8 R9 R10 command order
            check(got == exp, v.rf ? "R7 order" : "R8 order", got, exp);
            // R2 clock enable held high
            check(cke == 1'b1, "R2", cke, 1);
            if (got == K_PRE)
                check(addr[10] == 1'b1 && bank == 2'b00, "R4", {bank, addr}, 12'h400);
            if (got == K_MRS)
                check(addr == exp_mode(v) && bank == 2'b00,
                      scramble ? "R10 mode" : "R6", {bank, addr}, exp_mode(v));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) run_seq(VEC[i], 1'b0);

        // R10: configuration changes after release are ignored
        run_seq(VEC[1], 1'b1);
        run_seq(VEC[3], 1'b1);

        // R9: ready held for a while
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(ready == 1'b1 && sampled_kind() == K_RDY && cke == 1'b1, "R9 hold",
                  ready, 1);
        end

        // R9: reset mid-sequence restarts everything
        apply_reset(VEC[4]);
        repeat (30) @(posedge clk);
        @(negedge clk);
        check(ready == 1'b0, "R9 midway", ready, 0);
        run_seq(VEC[2], 1'b0);

        // R1 with reset held long while ready was high
        apply_reset(VEC[0]);
        check(ready == 1'b0, "R1 cleared", ready, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule